// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host offers one request at a time through a valid/ready handshake: a 17-bit address, a write flag and a byte of write data. The controller turns each request into a timed cycle on the RAM pins. It drives an active-low select, an active-high select, an active-low output enable, an active-low write enable, the address, and a split data bus with its own drive enable.

The RAM has no clock, so every timing minimum is met by counting controller clocks. The clock period and a speed-grade switch are parameters. Each nanosecond minimum is rounded up to whole cycles. A read holds the RAM selected with output enable low for the longest of the cycle time, the address access time and the output-enable access time. The byte is captured on the last counted cycle and returned with a one-cycle valid strobe. A write holds the write-enable overlap long enough for both the pulse width and the data setup. After a read comes a short turnaround gap before the next request, so the RAM can release the bus.

A power-down request puts the controller in a retention state that keeps the RAM deselected. When the request drops, a recovery wait of several milliseconds (a parameter) must pass before another access.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is high and on the cycle after it, both selects are inactive (`ram_sel_n`=1, `ram_sel`=0), `ram_oe_n`=1, `ram_we_n`=1, `ram_dq_oe`=0, `rsp_valid`=0 and `req_ready`=0.
- R2: A read holds both selects active, `ram_oe_n`=0 and `ram_we_n`=1 for exactly RD_CYC cycles, where RD_CYC is the ceiling of max(tRC, tAA, tOE) over the clock period (14 at 4 ns, fast grade). The byte present on the last of those cycles appears on `rsp_data` with `rsp_valid` high for one cycle. `rsp_valid` is first seen RD_CYC clocks after the accepting edge.
- R3: A write holds both selects active and `ram_we_n`=0 for WR_CYC cycles, the ceiling of max(tWP, tDW) over the period (10 at 4 ns, fast grade). `ram_oe_n` is never low at the same time as `ram_we_n`. The byte is then stored at the given address.
- R4: `ram_dq_oe` is high only while the write overlap is active. It is never high while `ram_oe_n` is low.
- R5: `req_ready` is low from the accepting edge until the cycle, turnaround or recovery in progress has ended. A write returns to ready WR_CYC cycles after acceptance.
- R6: After a read, a turnaround gap of TURN_CYC cycles (the output-disable float time rounded up, 5 at 4 ns, fast grade) passes before `req_ready` rises, so a read is busy for RD_CYC+TURN_CYC cycles.
- R7: While `pwr_down` is held and the controller is idle, the RAM stays deselected, the bus is released and `req_ready` is low. A request presented then has no effect on memory contents.
- R8: When `pwr_down` falls, `req_ready` returns after the recovery time rounded up to cycles, plus one cycle to leave retention.
- R9: The written byte on `ram_dq_o` stays constant for the whole write overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_data | output | 8 | Captured read byte |
| pwr_down | input | 1 | Retention request, holds RAM deselected |
| ram_addr | output | 17 | RAM address |
| ram_sel_n | output | 1 | Active-low RAM select |
| ram_sel | output | 1 | Active-high RAM select |
| ram_oe_n | output | 1 | Active-low RAM output enable |
| ram_we_n | output | 1 | Active-low RAM write enable |
| ram_dq_o | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` onto the bus |
| ram_dq_i | input | 8 | Data from the RAM |

## Verification
The assertions assume the host follows the handshake: it keeps fields stable while it waits and issues no request while reset is high. They also assume `pwr_down` does not toggle faster than the controller reacts. The bench drives every input on the falling edge, holds a request until `req_ready` is seen, and changes `pwr_down` only while the controller is idle. A RAM model in the bench returns a wrong byte until the counted access time has passed. It also flags a write overlap that is too short, data that changes within the pulse, and bus contention.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_TURN,
        ST_SLEEP,
        ST_WAKE
    } seq_state_e;

    // Pin strobes in positive logic; the top inverts the active-low ones.
    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic drive;
    } strobe_t;

    localparam strobe_t STRB_OFF   = '{sel: 1'b0, oe: 1'b0, we: 1'b0, drive: 1'b0};
    localparam strobe_t STRB_READ  = '{sel: 1'b1, oe: 1'b1, we: 1'b0, drive: 1'b0};
    localparam strobe_t STRB_WRITE = '{sel: 1'b1, oe: 1'b0, we: 1'b1, drive: 1'b1};

    // Round a time in ns up to whole clock cycles, at least one.
    function automatic int ns_to_cyc(input longint ns, input int period_ps);
        longint ps;
        longint c;
        ps = ns * 64'd1000;
        c  = (ps + longint'(period_ps) - 1) / longint'(period_ps);
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_cyc_fsm.sv
module sram_cyc_fsm
    import sram_ctl_pkg::*;
#(
    parameter int WR_CYC    = 10,
    parameter int RD_CYC    = 14,
    parameter int TURN_CYC  = 5,
    parameter int RECOV_CYC = 50,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             pwr_down,
    input  logic             tmr_zero,
    output logic             req_ready,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture,
    output strobe_t          strb,
    output seq_state_e       state
);
    localparam logic [CNT_W-1:0] WR_LD    = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);

    seq_state_e state_q, state_d;
    strobe_t    strb_q, strb_d;

    always_comb begin
        state_d   = state_q;
        strb_d    = strb_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        capture   = 1'b0;
        req_ready = (state_q == ST_IDLE) && !pwr_down && !rst;
        accept    = req_ready && req_valid;
        unique case (state_q)
            ST_IDLE: begin
                if (pwr_down) begin
                    state_d = ST_SLEEP;
                    strb_d  = STRB_OFF;
                end else if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WRITE;
                        tmr_val = WR_LD;
                        strb_d  = STRB_WRITE;
                    end else begin
                        state_d = ST_READ;
                        tmr_val = RD_LD;
                        strb_d  = STRB_READ;
                    end
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    capture  = 1'b1;
                    strb_d   = STRB_OFF;
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_LD;
                end
            end
            ST_WRITE: begin
                if (tmr_zero) begin
                    strb_d  = STRB_OFF;
                    state_d = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            ST_SLEEP: begin
                strb_d = STRB_OFF;
                if (!pwr_down) begin
                    state_d  = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = RECOV_LD;
                end
            end
            ST_WAKE: begin
                if (pwr_down)      state_d = ST_SLEEP;
                else if (tmr_zero) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                strb_d  = STRB_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            strb_q  <= STRB_OFF;
        end else begin
            state_q <= state_d;
            strb_q  <= strb_d;
        end
    end

    assign strb  = strb_q;
    assign state = state_q;
endmodule

// File: rtl/sram_cyc_dpath.sv
module sram_cyc_dpath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ram_dq_i,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_addr  <= '0;
            ram_dq_o  <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (accept) begin
                ram_addr <= req_addr;
                ram_dq_o <= req_wdata;
            end
            rsp_valid <= capture;
            if (capture) rsp_data <= ram_dq_i;
        end
    end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PS     = 4000,
    parameter bit FAST_GRADE = 1'b1,
    parameter int RECOV_NS   = 5000000,
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              pwr_down,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel_n,
    output logic              ram_sel,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_i
);
    // Grade-dependent minimums (ns).
    localparam int T_WP  = FAST_GRADE ? 40 : 50;
    localparam int T_DW  = FAST_GRADE ? 25 : 30;
    localparam int T_RC  = FAST_GRADE ? 55 : 70;
    localparam int T_AA  = FAST_GRADE ? 55 : 70;
    localparam int T_OE  = FAST_GRADE ? 30 : 35;
    localparam int T_OHZ = FAST_GRADE ? 20 : 25;

    localparam int WR_CYC    = max2(ns_to_cyc(T_WP, CLK_PS), ns_to_cyc(T_DW, CLK_PS));
    localparam int RD_CYC    = max2(max2(ns_to_cyc(T_RC, CLK_PS), ns_to_cyc(T_AA, CLK_PS)),
                                    ns_to_cyc(T_OE, CLK_PS));
    localparam int TURN_CYC  = ns_to_cyc(T_OHZ, CLK_PS);
    localparam int RECOV_CYC = ns_to_cyc(RECOV_NS, CLK_PS);
    localparam int MAX_CYC   = max2(max2(WR_CYC, RD_CYC), max2(TURN_CYC, RECOV_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    strobe_t          strb;
    seq_state_e       state;

    sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_cyc_fsm #(
        .WR_CYC    (WR_CYC),
        .RD_CYC    (RD_CYC),
        .TURN_CYC  (TURN_CYC),
        .RECOV_CYC (RECOV_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .pwr_down  (pwr_down),
        .tmr_zero  (tmr_zero),
        .req_ready (req_ready),
        .accept    (accept),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .capture   (capture),
        .strb      (strb),
        .state     (state)
    );

    sram_cyc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ram_dq_i  (ram_dq_i),
        .ram_addr  (ram_addr),
        .ram_dq_o  (ram_dq_o),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign ram_sel_n = ~strb.sel;
    assign ram_sel   =  strb.sel;
    assign ram_oe_n  = ~strb.oe;
    assign ram_we_n  = ~strb.we;
    assign ram_dq_oe =  strb.drive;
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              ram_sel_n,
    input logic              ram_sel,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic [DATA_W-1:0] ram_dq_o,
    input logic              ram_dq_oe,
    input seq_state_e        state
);
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R2

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!ram_oe_n && !ram_we_n)); // R3

    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> (!ram_we_n && !ram_sel_n && ram_sel && ram_oe_n)); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> !req_ready); // R5

    AST_SLEEP_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP) |-> (ram_sel_n && !ram_sel && !ram_dq_oe && !req_ready)); // R7

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_dq_o)); // R9
endmodule

bind sram_async_ctl sram_async_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ram_sel_n (ram_sel_n),
    .ram_sel   (ram_sel),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .ram_dq_o  (ram_dq_o),
    .ram_dq_oe (ram_dq_oe),
    .state     (state)
);

// File: tb/sram_async_ctl_tb_top.sv
module sram_async_ctl_tb_top;
    // 4 ns clock, fast grade: write max(40,25)ns -> 10, read max(55,55,30)ns -> 14,
    // turnaround 20ns -> 5, recovery override 200ns -> 50.
    localparam int WR_EXP    = 10;
    localparam int RD_EXP    = 14;
    localparam int TURN_EXP  = 5;
    localparam int RECOV_EXP = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        pwr_down = 1'b0;
    logic [16:0] ram_addr;
    logic        ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [7:0]  ram_dq_o;
    logic [7:0]  ram_dq_i;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sram_async_ctl #(.CLK_PS(4000), .FAST_GRADE(1'b1), .RECOV_NS(200)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pwr_down(pwr_down),
        .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_dq_o(ram_dq_o),
        .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
    );

    // ---------------- RAM model ----------------
    logic [7:0]  mem [int];
    int          wcnt = 0, rd_cnt = 0;
    logic [16:0] waddr = '0;
    logic [7:0]  wdat = '0, rd_word = '0;
    int          short_bad = 0, dat_bad = 0, drv_bad = 0, cont_bad = 0, commits = 0;

    always @(posedge clk) begin
        if (!ram_sel_n && ram_sel && !ram_we_n) begin
            wcnt  <= wcnt + 1;
            waddr <= ram_addr;
            wdat  <= ram_dq_o;
            if (!ram_dq_oe) drv_bad <= drv_bad + 1;
            if (wcnt != 0 && ram_dq_o != wdat) dat_bad <= dat_bad + 1;
        end else if (wcnt != 0) begin
            mem[int'(waddr)] = wdat;
            commits <= commits + 1;
            if (wcnt < WR_EXP) short_bad <= short_bad + 1;
            wcnt <= 0;
        end
        if (ram_dq_oe && !ram_oe_n) cont_bad <= cont_bad + 1;
        rd_cnt  <= (!ram_sel_n && ram_sel && !ram_oe_n && ram_we_n) ? rd_cnt + 1 : 0;
        rd_word <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
    end

    assign ram_dq_i = (rd_cnt + 1 >= RD_EXP) ? rd_word : 8'hEE;

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=finished", cyc);
            finish_run();
        end
    end

    // Issue one request; report busy length, response latency and data.
    task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                         output int busy, output int lat, output logic [7:0] rdat,
                         output int pulses, output bit ready_after_acc);
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ready_after_acc = req_ready;
        k = 0; lat = -1; rdat = 8'h00; pulses = 0;
        while (k < 500) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (rsp_valid) begin
                pulses++;
                if (lat < 0) begin lat = k; rdat = rsp_data; end
            end
            if (req_ready) break;
        end
        busy = k;
    endtask

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 17'h00000, 8'hA5},
        '{1'b1, 17'h1FFFF, 8'h5A},
        '{1'b1, 17'h0ABCD, 8'h3C},
        '{1'b0, 17'h00000, 8'hA5},
        '{1'b0, 17'h1FFFF, 8'h5A},
        '{1'b1, 17'h00000, 8'hFF},
        '{1'b0, 17'h00000, 8'hFF},
        '{1'b0, 17'h0ABCD, 8'h3C}
    };

    initial begin
        int busy, lat, pulses, k, c0;
        logic [7:0] rd;
        bit rdy;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "sel_n in reset", ram_sel_n, 1);
        check("R1", "sel in reset", ram_sel, 0);
        check("R1", "oe_n/we_n in reset", {ram_oe_n, ram_we_n}, 2'b11);
        check("R1", "dq_oe in reset", ram_dq_oe, 0);
        check("R1", "ready in reset", req_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "rsp_valid after reset", rsp_valid, 0);
        check("R1", "sel idle after reset", {ram_sel_n, ram_sel}, 2'b10);

        // Vector table
        foreach (VECS[i]) begin
            do_op(VECS[i].wr, VECS[i].addr, VECS[i].data, busy, lat, rd, pulses, rdy);
            check("R5", $sformatf("vec%0d ready after accept", i), rdy, 0);
            if (VECS[i].wr) begin
                check("R5", $sformatf("vec%0d write busy", i), busy, WR_EXP);
                check("R3", $sformatf("vec%0d no rsp on write", i), pulses, 0);
            end else begin
                check("R2", $sformatf("vec%0d read data", i), rd, VECS[i].data);
                check("R2", $sformatf("vec%0d read latency", i), lat, RD_EXP);
                check("R2", $sformatf("vec%0d strobe count", i), pulses, 1);
                check("R6", $sformatf("vec%0d read busy", i), busy, RD_EXP + TURN_EXP);
            end
        end

        // R7: retention with a pending write
        c0 = commits;
        @(negedge clk);
        pwr_down = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00000; req_wdata = 8'h11;
        repeat (20) @(negedge clk);
        check("R7", "ready in retention", req_ready, 0);
        check("R7", "deselected in retention", {ram_sel_n, ram_sel, ram_we_n}, 3'b101);
        check("R7", "bus released in retention", ram_dq_oe, 0);
        check("R7", "no write in retention", commits, c0);
        req_valid = 1'b0;

        // R8: recovery length
        pwr_down = 1'b0;
        k = 0;
        while (k < 1000) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (req_ready) break;
        end
        check("R8", "recovery cycles", k, RECOV_EXP + 1);

        // R7: memory untouched by request during retention
        do_op(1'b0, 17'h00000, 8'h00, busy, lat, rd, pulses, rdy);
        check("R7", "addr0 unchanged after retention", rd, 8'hFF);

        // Back-to-back write then read of the top address
        do_op(1'b1, 17'h1FFFF, 8'h81, busy, lat, rd, pulses, rdy);
        do_op(1'b0, 17'h1FFFF, 8'h00, busy, lat, rd, pulses, rdy);
        check("R2", "top address readback", rd, 8'h81);

        repeat (4) @(negedge clk);
        check("R3", "short write pulses", short_bad, 0);
        check("R9", "data change in pulse", dat_bad, 0);
        check("R4", "pulse without drive", drv_bad, 0);
        check("R4", "bus contention", cont_bad, 0);
        finish_run();
    end
endmodule